// File: doc/BRIEF.md
# Audio Link Reset and GPI Interrupt Controller

This block sits on the host side of a serial audio codec link and owns the link's reset behaviour. A three-bit control word, written over a simple single-cycle register bus, holds a GPI interrupt enable, an active-low cold-reset bit and a self-clearing warm-reset trigger. The cold-reset bit drives the link reset pin directly. A warm reset wakes a suspended codec without wiping its registers. The block raises SYNC for a programmable number of system clocks, then waits until the codec's bit clock toggles again.

The block samples the codec bit clock through a two-flop synchronizer. It treats the link as running when an edge has been seen within the last `IDLE_LIMIT` system clocks. A single-cycle GPI-change pulse from the link sets a sticky status bit, which software clears by writing 1 to it. The interrupt output is that bit gated by the enable. A separate power-management reset input returns the function from low power. It clears the GPI status and leaves all three control bits untouched. Only the full reset `rst_n` restores their defaults.

The register bus is plain control. A write takes effect at the clock edge where `wr_en` is high. A read is captured at the edge where `rd_en` is high and returned one cycle later with `rd_valid`. There is no back-pressure: every request is accepted in the cycle it is presented.

Top module: `audlink_ctrl`

## Requirements
- R1: The control word is at address 0: bit 0 is the GPI interrupt enable, bit 1 is the active-low cold-reset bit, and bit 2 is the warm-reset bit, which reads 1 while a warm reset is in progress. The status word is at address 1: bit 0 is the GPI status and bits 2:1 read 0. Read data is returned on `rdata` with `rd_valid` high in the cycle after `rd_en`.
- R2: After the full reset, the control word reads 000, `link_rst_n` is 0, and `sync_out` and `irq` are 0.
- R3: `link_rst_n` follows the cold-reset bit. Writing 0 to that bit asserts the link reset, aborts any warm reset in progress (SYNC drops and the warm bit reads 0 from the next cycle), and clears the GPI status.
- R4: Writing 1 to the warm-reset bit starts a warm reset, provided the bit clock is stopped, the same write holds the cold-reset bit at 1, and no warm reset is in progress. The warm bit then reads 1, and `sync_out` is high for exactly `SYNC_CYCLES` consecutive clocks (default 130).
- R5: A write of 1 to the warm-reset bit while `bclk_running` is 1 is ignored: the warm bit reads 0 and `sync_out` stays 0.
- R6: After SYNC is released, the warm bit stays 1 until a bit-clock edge has passed the synchronizer, then clears by itself.
- R7: `bclk_running` becomes 1 once a bit-clock edge has passed the synchronizer. It returns to 0 when no edge has been seen for `IDLE_LIMIT` system clocks (default 16). It is 0 after the full reset.
- R8: A `gpi_change` pulse sets the GPI status bit whatever the enable's value.
- R9: `irq` is 1 exactly while both the GPI status bit and the interrupt enable are 1.
- R10: Writing 1 to status bit 0 clears the GPI status. Writing 0 there has no effect. A set in the same cycle wins over the clear.
- R11: A low pulse on `pm_rst_n` clears the GPI status and leaves all three control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Full asynchronous reset, active low |
| pm_rst_n | input | 1 | Synchronous low-power-to-active function reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register select: 0 control, 1 status |
| wdata | input | 3 | Write data |
| rdata | output | 3 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| bclk_in | input | 1 | Codec bit clock, asynchronous |
| gpi_change | input | 1 | One-cycle pulse: a codec GPI changed |
| link_rst_n | output | 1 | Link reset pin, active low |
| sync_out | output | 1 | SYNC line drive during warm reset |
| bclk_running | output | 1 | Bit clock seen recently |
| irq | output | 1 | GPI interrupt request |

## Verification
The hardest situation to reach from the ports is the gap between the end of the SYNC pulse and the warm bit clearing by itself. In that gap the bit clock must stay stopped long enough to observe the warm bit still set. The bench therefore holds its bit-clock generator off while it counts the SYNC-high cycles and reads the control word in the waiting state. Only then does it enable the generator and expect the bit to clear. The bench also starts a warm reset and asserts cold reset while SYNC is still high, which reaches the abort path.

// File: rtl/audlink_pkg.sv
package audlink_pkg;
  localparam int unsigned CTRL_W = 3;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  localparam int unsigned BIT_GIE  = 0;
  localparam int unsigned BIT_COLD = 1;
  localparam int unsigned BIT_WARM = 2;
  localparam int unsigned BIT_GSTS = 0;

  typedef enum logic [1:0] {
    WARM_IDLE  = 2'd0,
    WARM_DRIVE = 2'd1,
    WARM_WAIT  = 2'd2
  } warm_state_e;
endpackage

// File: rtl/audlink_bclk_mon.sv
module audlink_bclk_mon #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDLE_LIMIT  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  output logic edge_o,
  output logic running_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_LIMIT);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic [CNT_W-1:0]       quiet_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= bclk_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], bclk_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[SYNC_STAGES-1];
  end

  assign edge_o = sync_q[SYNC_STAGES-1] ^ last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              quiet_q <= LIMIT;
    else if (edge_o)         quiet_q <= '0;
    else if (quiet_q != LIMIT) quiet_q <= quiet_q + 1'b1;
  end

  assign running_o = (quiet_q != LIMIT);

  assert_edge_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> running_o);
endmodule

// File: rtl/audlink_warm_seq.sv
module audlink_warm_seq
  import audlink_pkg::*;
#(
  parameter int unsigned SYNC_CYCLES = 130
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  input  logic bclk_edge_i,
  output logic busy_o,
  output logic sync_o
);
  localparam int unsigned CNT_W = $clog2(SYNC_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SYNC_CYCLES - 1);

  warm_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (abort_i) begin
      state_d = WARM_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        WARM_IDLE: if (start_i) begin
          state_d = WARM_DRIVE;
          cnt_d   = LOAD;
        end
        WARM_DRIVE: begin
          if (cnt_q == '0) state_d = WARM_WAIT;
          else             cnt_d   = cnt_q - 1'b1;
        end
        WARM_WAIT: if (bclk_edge_i) state_d = WARM_IDLE;
        default: state_d = WARM_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WARM_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o = (state_q != WARM_IDLE);
  assign sync_o = (state_q == WARM_DRIVE);

  assert_sync_from_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> $past(start_i));
  assert_clear_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(bclk_edge_i || abort_i));
endmodule

// File: rtl/audlink_gpi_irq.sv
module audlink_gpi_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic flush_i,
  input  logic ie_i,
  output logic sts_o,
  output logic irq_o
);
  logic sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sts_q <= 1'b0;
    else if (flush_i) sts_q <= 1'b0;
    else if (set_i)   sts_q <= 1'b1;
    else if (clr_i)   sts_q <= 1'b0;
  end

  assign sts_o = sts_q;
  assign irq_o = sts_q & ie_i;

  assert_gpi_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !flush_i) |=> sts_o);
  assert_gpi_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !sts_o);
endmodule

// File: rtl/audlink_ctrl.sv
module audlink_ctrl
  import audlink_pkg::*;
#(
  parameter int unsigned SYNC_CYCLES = 130,
  parameter int unsigned IDLE_LIMIT  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pm_rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output logic              rd_valid,
  input  logic              bclk_in,
  input  logic              gpi_change,
  output logic              link_rst_n,
  output logic              sync_out,
  output logic              bclk_running,
  output logic              irq
);
  logic gie_q, cold_n_q, cold_n_d;
  logic wr_ctrl, wr_stat;
  logic bclk_edge, warm_busy, warm_start, warm_abort;
  logic gpi_sts;
  logic [CTRL_W-1:0] rd_mux;

  assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
  assign wr_stat = wr_en && (addr == ADDR_STAT);

  // Control bits live only under the full reset; pm_rst_n does not reach them.
  assign cold_n_d = wr_ctrl ? wdata[BIT_COLD] : cold_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q    <= 1'b0;
      cold_n_q <= 1'b0;
    end else begin
      cold_n_q <= cold_n_d;
      if (wr_ctrl) gie_q <= wdata[BIT_GIE];
    end
  end

  assign warm_abort = !cold_n_d;
  assign warm_start = wr_ctrl && wdata[BIT_WARM] && wdata[BIT_COLD] &&
                      !warm_busy && !bclk_running;

  audlink_bclk_mon #(
    .SYNC_STAGES(SYNC_STAGES),
    .IDLE_LIMIT (IDLE_LIMIT)
  ) u_bclk_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk_i   (bclk_in),
    .edge_o   (bclk_edge),
    .running_o(bclk_running)
  );

  audlink_warm_seq #(
    .SYNC_CYCLES(SYNC_CYCLES)
  ) u_warm_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (warm_start),
    .abort_i    (warm_abort),
    .bclk_edge_i(bclk_edge),
    .busy_o     (warm_busy),
    .sync_o     (sync_out)
  );

  audlink_gpi_irq u_gpi (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (gpi_change),
    .clr_i  (wr_stat && wdata[BIT_GSTS]),
    .flush_i(!pm_rst_n || !cold_n_q),
    .ie_i   (gie_q),
    .sts_o  (gpi_sts),
    .irq_o  (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_CTRL) begin
      rd_mux[BIT_GIE]  = gie_q;
      rd_mux[BIT_COLD] = cold_n_q;
      rd_mux[BIT_WARM] = warm_busy;
    end else begin
      rd_mux[BIT_GSTS] = gpi_sts;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  assign link_rst_n = cold_n_q;

  assert_cold_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !link_rst_n |-> !sync_out);
  assert_warm_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[BIT_WARM] && !warm_busy && bclk_running) |=> !sync_out);
  assert_pm_keeps_ctrl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pm_rst_n && !wr_en) |=> $stable(link_rst_n));
endmodule

// File: tb/test_audlink_ctrl.sv
module test_audlink_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pm_rst_n = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [2:0] wdata = '0;
  logic [2:0] rdata;
  logic       rd_valid, bclk_in = 1'b0, bclk_en = 1'b0, gpi_change = 1'b0;
  logic       link_rst_n, sync_out, bclk_running, irq;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;
  always begin #40; if (bclk_en) bclk_in = ~bclk_in; end

  audlink_ctrl i_audlink_ctrl (
    .clk(clk), .rst_n(rst_n), .pm_rst_n(pm_rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .bclk_in(bclk_in), .gpi_change(gpi_change), .link_rst_n(link_rst_n),
    .sync_out(sync_out), .bclk_running(bclk_running), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [2:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Driver: pushes the expected read value, the monitor compares it.
  task automatic rd(input logic a, input logic [2:0] e, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check("R1 unexpected read", 1, 0);
      else check(tag_q.pop_front(), int'(rdata), int'(exp_q.pop_front()));
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) check("R1 reads outstanding", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      check("watchdog expired", 1, 0);
      finish_run();
    end
  end

  initial begin
    int hi;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    // R2 reset state
    check("R2 link_rst_n", link_rst_n, 0);
    check("R2 sync_out", sync_out, 0);
    check("R2 irq", irq, 0);
    check("R7 running after reset", bclk_running, 0);
    rd(1'b0, 3'b000, "R2 ctrl default");

    // R3 cold release
    wr(1'b0, 3'b010);
    check("R3 link_rst_n released", link_rst_n, 1);
    rd(1'b0, 3'b010, "R1 ctrl readback");

    // R4 warm reset, bit clock stopped
    wr(1'b0, 3'b110);
    hi = 0;
    for (int i = 0; i < 200; i++) begin
      if (sync_out) hi++;
      @(negedge clk);
    end
    check("R4 sync high cycles", hi, 130);
    // R6 warm bit held while waiting for bit clock
    cycles(50);
    rd(1'b0, 3'b110, "R6 warm held in wait");
    bclk_en = 1'b1;
    cycles(30);
    rd(1'b0, 3'b010, "R6 warm self-cleared");
    check("R7 running with bit clock", bclk_running, 1);

    // R5 refused while running
    wr(1'b0, 3'b110);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      if (sync_out) hi++;
      @(negedge clk);
    end
    check("R5 no sync while running", hi, 0);
    rd(1'b0, 3'b010, "R5 warm bit stays 0");

    // R8/R9 GPI with enable off
    @(negedge clk); gpi_change = 1'b1; @(negedge clk); gpi_change = 1'b0;
    check("R9 irq gated off", irq, 0);
    rd(1'b1, 3'b001, "R8 status set with enable off");
    // R10 write 0 has no effect, write 1 clears
    wr(1'b1, 3'b000);
    rd(1'b1, 3'b001, "R10 write 0 ignored");
    wr(1'b1, 3'b001);
    rd(1'b1, 3'b000, "R10 cleared");
    // enable on
    wr(1'b0, 3'b011);
    check("R9 irq idle", irq, 0);
    @(negedge clk); gpi_change = 1'b1; @(negedge clk); gpi_change = 1'b0;
    check("R9 irq raised", irq, 1);
    // R10 set wins over simultaneous clear
    @(negedge clk); gpi_change = 1'b1; wr_en = 1'b1; addr = 1'b1; wdata = 3'b001;
    @(negedge clk); gpi_change = 1'b0; wr_en = 1'b0;
    rd(1'b1, 3'b001, "R10 set beats clear");
    wr(1'b1, 3'b001);
    check("R9 irq after clear", irq, 0);

    // R11 function reset keeps control, clears status
    @(negedge clk); gpi_change = 1'b1; @(negedge clk); gpi_change = 1'b0;
    @(negedge clk); pm_rst_n = 1'b0; @(negedge clk); pm_rst_n = 1'b1;
    rd(1'b0, 3'b011, "R11 control retained");
    rd(1'b1, 3'b000, "R11 status cleared");
    check("R11 link_rst_n kept", link_rst_n, 1);
    check("R11 irq low", irq, 0);

    // R7 bit clock stops
    bclk_en = 1'b0;
    cycles(40);
    check("R7 running drops", bclk_running, 0);

    // R3 cold assert aborts warm reset and clears status
    @(negedge clk); gpi_change = 1'b1; @(negedge clk); gpi_change = 1'b0;
    wr(1'b0, 3'b111);
    cycles(10);
    check("R4 sync active", sync_out, 1);
    wr(1'b0, 3'b001);
    check("R3 sync aborted", sync_out, 0);
    check("R3 link_rst_n asserted", link_rst_n, 0);
    rd(1'b0, 3'b001, "R3 warm bit cleared by cold");
    rd(1'b1, 3'b000, "R3 status flushed");

    // R2 full reset restores defaults
    wr(1'b0, 3'b011);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    check("R2 link_rst_n after full reset", link_rst_n, 0);
    rd(1'b0, 3'b000, "R2 ctrl after full reset");
    cycles(3);
    done = 1;
    finish_run();
  end
endmodule